// File: doc/BRIEF.md
# PLL Bypass Relock Sequencer

This controller reprograms a clock PLL while the clock output is parked on the bypass source. A request carries new input-divider (M), feedback-divider (N) and post-divider (PL) values. The controller moves the output select to bypass. It then powers up or quiets the PLL, depending on which of two entry paths applies. It loads the coefficients while the loop is disabled, re-enables the loop and powers the lock detector. It polls the lock indication on a microsecond timebase. When lock is seen, it raises sync mode and only then returns the output to the VCO, so the switch back does not glitch.

Every control change takes its own state, and no two control outputs move in the same cycle. All delays are counted in pulses of a one-cycle microsecond tick. If lock does not arrive within the poll budget, the controller reports an error and leaves the output on bypass.

States and transitions:
- `ST_IDLE` goes to `ST_BYPASS` on a request.
- `ST_BYPASS` goes to `ST_PWRUP` when the PLL is still powered down. Otherwise it goes to `ST_SYNC_OFF`.
- `ST_PWRUP` goes to `ST_PWR_WAIT`, which goes to `ST_LOAD` when its timer expires.
- `ST_SYNC_OFF` goes to `ST_DISABLE`, which goes to `ST_LOAD`.
- `ST_LOAD` goes to `ST_ENABLE`.
- `ST_ENABLE` goes to `ST_LDET_ON` when the lock detector is off. Otherwise it goes to `ST_POLL`.
- `ST_LDET_ON` goes to `ST_POLL`.
- `ST_POLL` goes to `ST_SYNC_ON` on lock. It goes to `ST_FAIL` on the last poll without lock. Otherwise it goes to `ST_POLL_WAIT`.
- `ST_POLL_WAIT` goes back to `ST_POLL` when its timer expires.
- `ST_SYNC_ON` goes to `ST_TO_VCO`, which goes to `ST_IDLE`.
- `ST_FAIL` goes to `ST_IDLE`.

Top module: `pll_relock_seq`

## Requirements
- R1: A request (`req` high in idle) is accepted at that clock edge. The first output change is `sel_vco` going to 0 (bypass) one cycle later. Encoding: `sel_vco` 1 = VCO, 0 = bypass.
- R2: If `pll_iddq` is 1 (powered down) when the select moves to bypass, the next step drives `pll_iddq` to 0. Coefficients then load only after PWRUP_US further `us_tick` pulses. `pll_iddq` is never raised again outside reset.
- R3: If the PLL is already powered, `sync_mode` is driven to 0 first, and `pll_en` is driven to 0 on the following step.
- R4: `coef_m`, `coef_n` and `coef_pl` change only while `pll_en` is 0, and take the requested values. `pll_en` rises on the step after the load.
- R5: If `lckdet_pwr` is 0 when the loop is enabled, it is driven to 1 on the next step.
- R6: `pll_lock` is sampled first on the step after enable (or after detector power-on). It is then sampled again each time POLL_US ticks have passed, for at most LOCK_DELAY_US/2+1 samples.
- R7: On a lock sample, `sync_mode` goes to 1. On the next step, `sel_vco` goes to 1 together with a one-cycle `done` pulse.
- R8: When the last sample shows no lock, `lock_err` pulses for one cycle and `sel_vco` stays 0. The block is then idle and accepts the next request.
- R9: A request raised while a sequence is in progress is ignored, and its coefficient values never reach the outputs.
- R10: At most one of `sel_vco`, `pll_iddq`, `pll_en`, `lckdet_pwr`, `sync_mode` and the coefficient set changes in any one cycle.
- R11: After reset: `sel_vco`=0, `pll_iddq`=1, `pll_en`=0, `lckdet_pwr`=0, `sync_mode`=0, coefficients 0, `done`=0, `lock_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| req | input | 1 | Start a reprogramming sequence (taken only when idle) |
| req_m | input | M_W | Requested input divider |
| req_n | input | N_W | Requested feedback divider |
| req_pl | input | PL_W | Requested post divider |
| pll_lock | input | 1 | Lock indication from the PLL |
| sel_vco | output | 1 | Output select: 1 VCO, 0 bypass |
| pll_iddq | output | 1 | PLL power-down: 1 powered down |
| pll_en | output | 1 | PLL enable |
| lckdet_pwr | output | 1 | Lock-detector power |
| sync_mode | output | 1 | Sync mode for glitch-free output switching |
| coef_m | output | M_W | Programmed input divider |
| coef_n | output | N_W | Programmed feedback divider |
| coef_pl | output | PL_W | Programmed post divider |
| done | output | 1 | One-cycle pulse on successful relock |
| lock_err | output | 1 | One-cycle pulse on lock timeout |

## Verification
The first request is taken from the reset state. It exercises the power-down release and the 5-tick settle, and lock is delayed by several polls so the 2-tick poll spacing is visible. The second request starts with the PLL running, which selects the sync-off and disable ordering and skips the detector power step. A conflicting request is injected while this sequence is in progress. A third request never sees lock. It shows the exact poll budget, the error pulse and the output staying on bypass. A final request then proves that the block recovers.

// File: rtl/pll_relock_pkg.sv
package pll_relock_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BYPASS,
        ST_PWRUP,
        ST_PWR_WAIT,
        ST_SYNC_OFF,
        ST_DISABLE,
        ST_LOAD,
        ST_ENABLE,
        ST_LDET_ON,
        ST_POLL,
        ST_POLL_WAIT,
        ST_SYNC_ON,
        ST_TO_VCO,
        ST_FAIL
    } relock_state_t;

endpackage

// File: rtl/relock_us_timer.sv
module relock_us_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             us_tick,
    output logic             expired
);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (us_tick && remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign expired = (remain == '0);

    // Counter only moves down between loads
    assert_timer_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load) |-> remain <= $past(remain));

endmodule

// File: rtl/relock_poll_ctr.sv
module relock_poll_ctr #(
    parameter int LIMIT = 151
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);

    localparam int PC_W = $clog2(LIMIT + 1);

    logic [PC_W-1:0] polls;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            polls <= '0;
        end else if (clr) begin
            polls <= '0;
        end else if (inc && polls != PC_W'(LIMIT)) begin
            polls <= polls + 1'b1;
        end
    end

    assign last = (polls == PC_W'(LIMIT - 1));

    assert_poll_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        polls <= PC_W'(LIMIT));

endmodule

// File: rtl/pll_relock_seq.sv
module pll_relock_seq
    import pll_relock_pkg::*;
#(
    parameter int M_W           = 8,
    parameter int N_W           = 8,
    parameter int PL_W          = 6,
    parameter int LOCK_DELAY_US = 300,
    parameter int PWRUP_US      = 5,
    parameter int POLL_US       = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            us_tick,
    input  logic            req,
    input  logic [M_W-1:0]  req_m,
    input  logic [N_W-1:0]  req_n,
    input  logic [PL_W-1:0] req_pl,
    input  logic            pll_lock,
    output logic            sel_vco,
    output logic            pll_iddq,
    output logic            pll_en,
    output logic            lckdet_pwr,
    output logic            sync_mode,
    output logic [M_W-1:0]  coef_m,
    output logic [N_W-1:0]  coef_n,
    output logic [PL_W-1:0] coef_pl,
    output logic            done,
    output logic            lock_err
);

    localparam int POLL_LIMIT = LOCK_DELAY_US / 2 + 1;
    localparam int TMR_MAX    = (PWRUP_US > POLL_US) ? PWRUP_US : POLL_US;
    localparam int TMR_W      = $clog2(TMR_MAX + 1);

    relock_state_t state, state_nx;

    logic [M_W-1:0]  hold_m;
    logic [N_W-1:0]  hold_n;
    logic [PL_W-1:0] hold_pl;

    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             poll_clr;
    logic             poll_inc;
    logic             poll_last;

    // ---------------- timers ----------------
    assign tmr_load = (state == ST_PWRUP) ||
                      (state == ST_POLL && !pll_lock && !poll_last);
    assign tmr_val  = (state == ST_PWRUP) ? TMR_W'(PWRUP_US) : TMR_W'(POLL_US);
    assign poll_clr = (state == ST_ENABLE);
    assign poll_inc = (state == ST_POLL) && !pll_lock;

    relock_us_timer #(.CNT_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .us_tick  (us_tick),
        .expired  (tmr_expired)
    );

    relock_poll_ctr #(.LIMIT(POLL_LIMIT)) u_polls (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (poll_clr),
        .inc   (poll_inc),
        .last  (poll_last)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (req) state_nx = ST_BYPASS;
            ST_BYPASS:    state_nx = pll_iddq ? ST_PWRUP : ST_SYNC_OFF;
            ST_PWRUP:     state_nx = ST_PWR_WAIT;
            ST_PWR_WAIT:  if (tmr_expired) state_nx = ST_LOAD;
            ST_SYNC_OFF:  state_nx = ST_DISABLE;
            ST_DISABLE:   state_nx = ST_LOAD;
            ST_LOAD:      state_nx = ST_ENABLE;
            ST_ENABLE:    state_nx = lckdet_pwr ? ST_POLL : ST_LDET_ON;
            ST_LDET_ON:   state_nx = ST_POLL;
            ST_POLL: begin
                if (pll_lock)       state_nx = ST_SYNC_ON;
                else if (poll_last) state_nx = ST_FAIL;
                else                state_nx = ST_POLL_WAIT;
            end
            ST_POLL_WAIT: if (tmr_expired) state_nx = ST_POLL;
            ST_SYNC_ON:   state_nx = ST_TO_VCO;
            ST_TO_VCO:    state_nx = ST_IDLE;
            ST_FAIL:      state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_vco    <= 1'b0;
            pll_iddq   <= 1'b1;
            pll_en     <= 1'b0;
            lckdet_pwr <= 1'b0;
            sync_mode  <= 1'b0;
            coef_m     <= '0;
            coef_n     <= '0;
            coef_pl    <= '0;
            hold_m     <= '0;
            hold_n     <= '0;
            hold_pl    <= '0;
            done       <= 1'b0;
            lock_err   <= 1'b0;
        end else begin
            done     <= 1'b0;
            lock_err <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req) begin
                        hold_m  <= req_m;
                        hold_n  <= req_n;
                        hold_pl <= req_pl;
                    end
                end
                ST_BYPASS:   sel_vco    <= 1'b0;
                ST_PWRUP:    pll_iddq   <= 1'b0;
                ST_SYNC_OFF: sync_mode  <= 1'b0;
                ST_DISABLE:  pll_en     <= 1'b0;
                ST_LOAD: begin
                    coef_m  <= hold_m;
                    coef_n  <= hold_n;
                    coef_pl <= hold_pl;
                end
                ST_ENABLE:   pll_en     <= 1'b1;
                ST_LDET_ON:  lckdet_pwr <= 1'b1;
                ST_SYNC_ON:  sync_mode  <= 1'b1;
                ST_TO_VCO: begin
                    sel_vco <= 1'b1;
                    done    <= 1'b1;
                end
                ST_FAIL:     lock_err   <= 1'b1;
                default: ;
            endcase
        end
    end

    // ---------------- assertions ----------------
    assert_coef_while_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({coef_m, coef_n, coef_pl}) |-> (!pll_en && !$past(pll_en)));

    assert_one_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!$stable(sel_vco), !$stable(pll_iddq), !$stable(pll_en),
                    !$stable(lckdet_pwr), !$stable(sync_mode),
                    !$stable({coef_m, coef_n, coef_pl})}) <= 1);

    assert_vco_after_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_vco) |-> (sync_mode && $past(sync_mode) && pll_en && done));

    assert_sync_low_on_disable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_en) |-> !sync_mode);

    assert_err_on_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lock_err |-> (!sel_vco && !done));

    assert_iddq_stays_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(pll_iddq));

endmodule

// File: tb/pll_relock_seq_bench.sv
module pll_relock_seq_bench;

    localparam int M_W = 8, N_W = 8, PL_W = 6;
    localparam int LOCK_DELAY_US = 300;
    localparam int PWRUP_US = 5;
    localparam int POLL_US = 2;
    localparam int POLL_LIMIT = LOCK_DELAY_US / 2 + 1;
    localparam int NEVER = 1 << 30;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            us_tick = 1'b0;
    logic            req = 1'b0;
    logic [M_W-1:0]  req_m = '0;
    logic [N_W-1:0]  req_n = '0;
    logic [PL_W-1:0] req_pl = '0;
    logic            pll_lock = 1'b0;
    logic            sel_vco, pll_iddq, pll_en, lckdet_pwr, sync_mode, done, lock_err;
    logic [M_W-1:0]  coef_m;
    logic [N_W-1:0]  coef_n;
    logic [PL_W-1:0] coef_pl;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int lock_after = NEVER;
    int lk_cnt = 0;

    // reference model state
    bit m_sel = 0, m_iddq = 1, m_en = 0, m_ldet = 0, m_sync = 0, m_done = 0, m_err = 0;
    int m_m = 0, m_n = 0, m_pl = 0;

    pll_relock_seq u_pll_relock_seq (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .req(req),
        .req_m(req_m), .req_n(req_n), .req_pl(req_pl), .pll_lock(pll_lock),
        .sel_vco(sel_vco), .pll_iddq(pll_iddq), .pll_en(pll_en),
        .lckdet_pwr(lckdet_pwr), .sync_mode(sync_mode),
        .coef_m(coef_m), .coef_n(coef_n), .coef_pl(coef_pl),
        .done(done), .lock_err(lock_err)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    // microsecond tick and PLL lock behaviour
    always @(negedge clk) begin
        cyc++;
        us_tick <= (cyc % 4 == 3);
        if (!pll_en) lk_cnt = 0;
        else lk_cnt++;
        pll_lock <= pll_en && (lk_cnt >= lock_after);
    end

    task automatic count_ticks(input int n);
        int c = 0;
        while (c < n) begin
            @(posedge clk);
            if (us_tick) c++;
        end
    endtask

    // behavioural reference model
    initial begin
        int polls;
        int rm, rn, rpl;
        bit got;
        wait (rst_n);
        forever begin
            @(posedge clk);
            m_done = 0;
            m_err = 0;
            if (req) begin
                rm = int'(req_m); rn = int'(req_n); rpl = int'(req_pl);
                @(posedge clk); m_sel = 0;
                if (m_iddq) begin
                    @(posedge clk); m_iddq = 0;
                    count_ticks(PWRUP_US);
                    @(posedge clk);
                end else begin
                    @(posedge clk); m_sync = 0;
                    @(posedge clk); m_en = 0;
                end
                @(posedge clk); m_m = rm; m_n = rn; m_pl = rpl;
                @(posedge clk); m_en = 1;
                if (!m_ldet) begin
                    @(posedge clk); m_ldet = 1;
                end
                polls = 0;
                got = 0;
                forever begin
                    @(posedge clk);
                    if (pll_lock) begin got = 1; break; end
                    polls++;
                    if (polls == POLL_LIMIT) break;
                    count_ticks(POLL_US);
                    @(posedge clk);
                end
                if (got) begin
                    @(posedge clk); m_sync = 1;
                    @(posedge clk); m_sel = 1; m_done = 1;
                end else begin
                    @(posedge clk); m_err = 1;
                end
            end
        end
    end

    // per-cycle comparison and single-change check
    bit p_sel, p_iddq, p_en, p_ldet, p_sync;
    int p_coef;
    bit have_prev = 0;
    always @(negedge clk) begin
        int nchg;
        check(sel_vco == m_sel, "R1/R7", "sel_vco", sel_vco, m_sel);
        check(pll_iddq == m_iddq, "R2", "pll_iddq", pll_iddq, m_iddq);
        check(sync_mode == m_sync, "R3", "sync_mode", sync_mode, m_sync);
        check(pll_en == m_en, "R4", "pll_en", pll_en, m_en);
        check(int'(coef_m) == m_m && int'(coef_n) == m_n && int'(coef_pl) == m_pl,
              "R4", "coef_n", coef_n, m_n);
        check(lckdet_pwr == m_ldet, "R5", "lckdet_pwr", lckdet_pwr, m_ldet);
        check(done == m_done, "R7", "done", done, m_done);
        check(lock_err == m_err, "R8", "lock_err", lock_err, m_err);
        if (have_prev && rst_n) begin
            nchg = int'(sel_vco != p_sel) + int'(pll_iddq != p_iddq) + int'(pll_en != p_en)
                 + int'(lckdet_pwr != p_ldet) + int'(sync_mode != p_sync)
                 + int'({coef_m, coef_n, coef_pl} != p_coef[M_W+N_W+PL_W-1:0]);
            check(nchg <= 1, "R10", "changes per cycle", nchg, 1);
        end
        p_sel = sel_vco; p_iddq = pll_iddq; p_en = pll_en; p_ldet = lckdet_pwr;
        p_sync = sync_mode; p_coef = int'({coef_m, coef_n, coef_pl});
        have_prev = 1;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic request(input int m, input int n, input int pl);
        @(negedge clk);
        req = 1; req_m = M_W'(m); req_n = N_W'(n); req_pl = PL_W'(pl);
        @(negedge clk);
        req = 0;
    endtask

    task automatic wait_end(output bit ok, output bit err, output int ticks);
        ok = 0; err = 0; ticks = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (us_tick) ticks++;
            if (done) begin ok = 1; break; end
            if (lock_err) begin err = 1; break; end
        end
    endtask

    initial begin
        bit ok, err;
        int ticks;
        repeat (3) @(negedge clk);
        // R11 reset state
        check(sel_vco == 0 && pll_iddq == 1 && pll_en == 0 && lckdet_pwr == 0 &&
              sync_mode == 0 && done == 0 && lock_err == 0, "R11", "reset outputs",
              {sel_vco, pll_iddq, pll_en}, 3'b010);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // first power-up path, lock after a few polls (R2, R5, R6, R7)
        lock_after = 40;
        request(2, 100, 3);
        wait_end(ok, err, ticks);
        check(ok && !err, "R7", "first relock done", ok, 1);
        check(sel_vco == 1 && coef_n == 100 && coef_m == 2 && coef_pl == 3, "R4",
              "first coef_n", coef_n, 100);
        repeat (4) @(negedge clk);

        // running path with conflicting request mid-sequence (R3, R9)
        lock_after = 0;
        request(3, 120, 2);
        repeat (2) @(negedge clk);
        req = 1; req_m = 9; req_n = 9; req_pl = 9;
        @(negedge clk);
        req = 0;
        wait_end(ok, err, ticks);
        check(ok, "R3", "running-path relock done", ok, 1);
        check(coef_n == 120 && coef_m == 3, "R9", "busy request ignored coef_n",
              coef_n, 120);
        repeat (4) @(negedge clk);

        // lock never arrives (R6, R8)
        lock_after = NEVER;
        request(4, 90, 5);
        wait_end(ok, err, ticks);
        check(err && !ok, "R8", "lock_err raised", err, 1);
        check(sel_vco == 0, "R8", "stays on bypass", sel_vco, 0);
        check(ticks >= POLL_US * (POLL_LIMIT - 1) && ticks <= POLL_US * POLL_LIMIT + POLL_LIMIT + 4,
              "R6", "ticks before timeout", ticks, POLL_US * (POLL_LIMIT - 1));
        repeat (4) @(negedge clk);

        // recovery after failure (R8, R1)
        lock_after = 10;
        request(1, 200, 1);
        wait_end(ok, err, ticks);
        check(ok && sel_vco == 1 && coef_n == 200, "R8", "recovery relock coef_n",
              coef_n, 200);
        repeat (4) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule